// File: doc/BRIEF.md
# Tiled Framebuffer Scanout Address Generator

This block turns one frame of scanout into a stream of memory read requests. A table of 16-bit tile pointers sits in memory. The block reads the entries one at a time. It turns each entry into the 32-bit address of a 64 KB tile and issues the pixel reads that tile holds for the visible screen. Each pixel read also carries the byte offset where its data lands in a linear output framebuffer. The downstream data path uses that offset to place the bytes it gets back.

Two layouts are supported. In tiled mode a tile is 128 lines of 512 bytes. The walk goes left to right and then top to bottom, and it clips at the right and bottom screen edges. In linear mode a tile is a contiguous 64 KB block. It is fetched in fixed-size chunks until exactly width × height × bytes-per-pixel bytes have been requested. A one-cycle start pulse latches the whole configuration, and a one-cycle done pulse closes the frame.

Top module: `tile_scan_agu`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `req_valid` are low.
- R2: At start, the table base is taken as `cfg_table_base` with bits 8..0 cleared. If that base is zero, or if width or height is zero, the block issues no request and raises `done` on the cycle after start is sampled.
- R3: Table entry i is requested with `req_table`=1, address base + 2·i and length 2. The entries are read in order. After each table request the block waits for `rsp_valid` before it issues anything else. The tile address is `rsp_data` shifted left by 16, and `rsp_data[15:8]` is the byte at the lower address.
- R4: In tiled mode, line l of a tile is read at tile + 512·l with length pixels × bytes-per-pixel. The lines are issued in increasing order.
- R5: Depth code 0, 1 and 2 select 8, 16 and 32 bits per pixel, and code 3 also selects 32. The tile width in pixels is 4096 / bpp.
- R6: In tiled mode, after each tile the column base advances by one tile width. When it reaches the width, it returns to 0 and the row base advances by 128. The frame ends when the row base reaches the height.
- R7: A tile in the last column reads only width − xbase pixels per line. A tile in the last row reads only height − ybase lines.
- R8: The destination of a tiled line is ((ybase + l) · width + xbase) · bytes-per-pixel.
- R9: In linear mode each tile is read in chunks of 2^CHUNK_LG2 bytes at tile + offset, and the destination is a running byte count. After 64 KB the next table entry is fetched. The final chunk is cut so that the total equals width · height · bytes-per-pixel.
- R10: `done` is a single-cycle pulse. It rises in the cycle after the last request is accepted. `busy` is high from start until `done`.
- R11: Configuration inputs and further start pulses have no effect while a frame is in progress.
- R12: While `req_valid` is high and `req_ready` is low, the request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame and latches configuration |
| cfg_table_base | input | 32 | Tile-table address; bits 8..0 ignored |
| cfg_linear | input | 1 | 1 = linear tiles, 0 = 512×128 tiles |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_width | input | DIM_W | Screen width in pixels |
| cfg_height | input | DIM_W | Screen height in lines |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Request accepted this cycle |
| req_table | output | 1 | Request is a table-entry read |
| req_addr | output | 32 | Byte address to read |
| req_len | output | LEN_W | Bytes to read |
| req_dst | output | 32 | Destination byte offset (pixel reads) |
| rsp_valid | input | 1 | Table entry returned |
| rsp_data | input | 16 | Table entry value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished pulse |

## Verification
Tiled frames are run at all four depth codes. Some widths and heights are exact multiples of the tile size and others leave partial tiles, so full tiles are separated from clipped right columns and bottom rows. Linear frames cover a total that ends partway through a chunk, one that is exactly one chunk, and one that spans several 64 KB tiles. These separate chunk shortening from tile advance. Zero base and zero width check the empty frame. A frame where the configuration is disturbed and start is pulsed again shows that the latched values rule. Random backpressure on `req_ready` and random table-response delays run through all of them.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TREQ,
        S_TWAIT,
        S_PIX,
        S_DONE
    } scan_st_e;

    localparam int ROW_BYTES_LG2 = 9;
    localparam int TILE_LINES    = 128;

    // depth code to log2 of bytes per pixel; code 3 behaves as 32 bpp
    function automatic logic [1:0] depth_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/tscan_span.sv
// Remaining-length clipper: how much of a step fits before a limit,
// and whether this step reaches the limit.
module tscan_span #(
    parameter int W = 13
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] step,
    output logic [W-1:0] span,
    output logic         last
);
    logic [W:0] rem;

    always_comb begin
        rem  = {1'b0, limit} - {1'b0, pos};
        last = ({1'b0, step} >= rem);
        span = last ? rem[W-1:0] : step;
    end
endmodule

// File: rtl/tscan_dst.sv
// Linear framebuffer byte offset of a tiled line segment.
module tscan_dst #(
    parameter int P = 13
) (
    input  logic [P-1:0] row,
    input  logic [P-1:0] width,
    input  logic [P-1:0] col,
    input  logic [1:0]   sh,
    output logic [31:0]  dst
);
    logic [31:0] pix;

    always_comb begin
        pix = 32'(row) * 32'(width) + 32'(col);
        dst = pix << sh;
    end
endmodule

// File: rtl/tile_scan_agu.sv
module tile_scan_agu
    import tscan_pkg::*;
#(
    parameter int DIM_W     = 12,
    parameter int CHUNK_LG2 = 14,
    parameter int LEN_W     = ((CHUNK_LG2 > ROW_BYTES_LG2) ? CHUNK_LG2 : ROW_BYTES_LG2) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      cfg_table_base,
    input  logic             cfg_linear,
    input  logic [1:0]       cfg_depth,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_table,
    output logic [31:0]      req_addr,
    output logic [LEN_W-1:0] req_len,
    output logic [31:0]      req_dst,
    input  logic             rsp_valid,
    input  logic [15:0]      rsp_data,
    output logic             busy,
    output logic             done
);
    localparam int P     = DIM_W + 1;
    localparam int CHUNK = 1 << CHUNK_LG2;

    typedef struct packed {
        scan_st_e    st;
        logic [31:0] base;
        logic        lin;
        logic [1:0]  sh;
        logic [P-1:0] w;
        logic [P-1:0] h;
        logic [15:0] tnr;
        logic [15:0] tile;
        logic [P-1:0] xb;
        logic [P-1:0] yb;
        logic [6:0]  line;
        logic [16:0] off;
        logic [31:0] fbo;
    } scan_t;

    scan_t q, d;

    // derived geometry of the current tile
    logic [P-1:0] tile_px;
    logic [P-1:0] px_cnt, ln_cnt;
    logic         x_last, y_last, line_last;
    logic [31:0]  total, ch_len;
    logic         l_last;
    logic [P-1:0] row;
    logic [31:0]  tdst;
    logic [31:0]  tile_addr;
    logic [16:0]  off_nxt;

    always_comb begin
        tile_px   = P'(512) >> q.sh;
        total     = (32'(q.w) * 32'(q.h)) << q.sh;
        row       = q.yb + P'(q.line);
        tile_addr = {q.tile, 16'h0000};
        line_last = (P'(q.line) + P'(1)) == ln_cnt;
        off_nxt   = q.off + 17'(CHUNK);
    end

    tscan_span #(.W(P)) u_xspan (
        .pos(q.xb), .limit(q.w), .step(tile_px), .span(px_cnt), .last(x_last)
    );

    tscan_span #(.W(P)) u_yspan (
        .pos(q.yb), .limit(q.h), .step(P'(TILE_LINES)), .span(ln_cnt), .last(y_last)
    );

    tscan_span #(.W(32)) u_lspan (
        .pos(q.fbo), .limit(total), .step(32'(CHUNK)), .span(ch_len), .last(l_last)
    );

    tscan_dst #(.P(P)) u_dst (
        .row(row), .width(q.w), .col(q.xb), .sh(q.sh), .dst(tdst)
    );

    // next-state
    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.base = {cfg_table_base[31:9], 9'h000};
                    d.lin  = cfg_linear;
                    d.sh   = depth_shift(cfg_depth);
                    d.w    = P'(cfg_width);
                    d.h    = P'(cfg_height);
                    d.tnr  = '0;
                    d.tile = '0;
                    d.xb   = '0;
                    d.yb   = '0;
                    d.line = '0;
                    d.off  = '0;
                    d.fbo  = '0;
                    if (cfg_table_base[31:9] == '0 || cfg_width == '0 || cfg_height == '0)
                        d.st = S_DONE;
                    else
                        d.st = S_TREQ;
                end
            end
            S_TREQ: begin
                if (req_ready) d.st = S_TWAIT;
            end
            S_TWAIT: begin
                if (rsp_valid) begin
                    d.tile = rsp_data;
                    d.st   = S_PIX;
                end
            end
            S_PIX: begin
                if (req_ready) begin
                    if (q.lin) begin
                        d.fbo = q.fbo + ch_len;
                        if (l_last) begin
                            d.st = S_DONE;
                        end else if (off_nxt[16]) begin
                            d.off = '0;
                            d.tnr = q.tnr + 16'd1;
                            d.st  = S_TREQ;
                        end else begin
                            d.off = off_nxt;
                        end
                    end else if (line_last) begin
                        d.line = '0;
                        if (x_last) begin
                            d.xb = '0;
                            if (y_last) begin
                                d.st = S_DONE;
                            end else begin
                                d.yb  = q.yb + P'(TILE_LINES);
                                d.tnr = q.tnr + 16'd1;
                                d.st  = S_TREQ;
                            end
                        end else begin
                            d.xb  = q.xb + tile_px;
                            d.tnr = q.tnr + 16'd1;
                            d.st  = S_TREQ;
                        end
                    end else begin
                        d.line = q.line + 7'd1;
                    end
                end
            end
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    // request outputs
    always_comb begin
        req_valid = 1'b0;
        req_table = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_dst   = '0;
        if (q.st == S_TREQ) begin
            req_valid = 1'b1;
            req_table = 1'b1;
            req_addr  = q.base + {15'h0, q.tnr, 1'b0};
            req_len   = LEN_W'(2);
        end else if (q.st == S_PIX) begin
            req_valid = 1'b1;
            if (q.lin) begin
                req_addr = tile_addr + 32'(q.off);
                req_len  = LEN_W'(ch_len);
                req_dst  = q.fbo;
            end else begin
                req_addr = tile_addr + {16'h0, q.line, 9'h000};
                req_len  = LEN_W'(32'(px_cnt) << q.sh);
                req_dst  = tdst;
            end
        end
        busy = (q.st != S_IDLE);
        done = (q.st == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // R12: request held until accepted
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
                                    && $stable(req_dst) && $stable(req_table));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no request outside a frame
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // R9: a pixel read stays inside its 64 KB tile
    a_r9_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_table |-> (17'(req_addr[15:0]) + 17'(req_len)) <= 17'h10000);

    // R3: table reads are two bytes at an even address
    a_r3_tbl_shape: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_table |-> req_addr[0] == 1'b0 && req_len == LEN_W'(2));

    // R7: clipping never yields an empty read
    a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len != '0);

    // R3: no pixel read directly after a table request is accepted
    a_r3_wait_entry: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_table && req_ready |=> !req_valid);

endmodule

// File: tb/tile_scan_agu_test.sv
module tile_scan_agu_test;
    localparam int DIM_W     = 12;
    localparam int CHUNK_LG2 = 14;
    localparam int LEN_W     = 15;
    localparam int CHUNK     = 1 << CHUNK_LG2;
    localparam int EMAX      = 8192;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      cfg_table_base = '0;
    logic             cfg_linear = 1'b0;
    logic [1:0]       cfg_depth = '0;
    logic [DIM_W-1:0] cfg_width = '0;
    logic [DIM_W-1:0] cfg_height = '0;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic             req_table;
    logic [31:0]      req_addr;
    logic [LEN_W-1:0] req_len;
    logic [31:0]      req_dst;
    logic             rsp_valid = 1'b0;
    logic [15:0]      rsp_data = '0;
    logic             busy;
    logic             done;

    always #2.5 clk = ~clk;

    tile_scan_agu #(.DIM_W(DIM_W), .CHUNK_LG2(CHUNK_LG2), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_table_base(cfg_table_base), .cfg_linear(cfg_linear),
        .cfg_depth(cfg_depth), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .req_valid(req_valid), .req_ready(req_ready), .req_table(req_table),
        .req_addr(req_addr), .req_len(req_len), .req_dst(req_dst),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    // expected request list
    bit          e_tbl  [EMAX];
    logic [31:0] e_addr [EMAX];
    int          e_len  [EMAX];
    logic [31:0] e_dst  [EMAX];
    int          e_n = 0;
    logic [31:0] e_base = '0;

    int got = 0;
    int got0 = 0;
    int done_cnt = 0;
    int cyc = 0;
    int pend = 0;
    int pend_idx = 0;
    bit want_done = 0;

    function automatic logic [15:0] ent(input int idx);
        return 16'(32'h0800 + idx * 32'h0111);
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic push(input bit t, input logic [31:0] a, input int l, input logic [31:0] ds);
        if (e_n < EMAX) begin
            e_tbl[e_n] = t; e_addr[e_n] = a; e_len[e_n] = l; e_dst[e_n] = ds;
            e_n++;
        end
    endtask

    // expected sequence from the requirements
    task automatic build(input bit lin, input logic [1:0] dep, input int w, input int h,
                         input logic [31:0] braw);
        int sh, bb, idx;
        logic [31:0] tile;
        e_n = 0;
        e_base = braw & 32'hFFFF_FE00;
        if (e_base == 0 || w == 0 || h == 0) return;
        sh = (dep == 0) ? 0 : (dep == 1) ? 1 : 2;       // R5
        bb = 1 << sh;
        idx = 0;
        if (lin) begin                                   // R9
            int total, fbo, len;
            total = w * h * bb;
            fbo = 0;
            forever begin
                push(1, e_base + 32'(2 * idx), 2, 0);
                tile = {ent(idx), 16'h0};
                for (int off = 0; off < 65536; off += CHUNK) begin
                    len = (total - fbo < CHUNK) ? total - fbo : CHUNK;
                    push(0, tile + 32'(off), len, 32'(fbo));
                    fbo += len;
                    if (fbo == total) return;
                end
                idx++;
            end
        end else begin                                   // R4 R6 R7 R8
            int tpx, lines, px;
            tpx = 512 >> sh;
            for (int yb = 0; yb < h; yb += 128) begin
                for (int xb = 0; xb < w; xb += tpx) begin
                    push(1, e_base + 32'(2 * idx), 2, 0);
                    tile = {ent(idx), 16'h0};
                    lines = (h - yb < 128) ? h - yb : 128;
                    px = (w - xb < tpx) ? w - xb : tpx;
                    for (int l = 0; l < lines; l++)
                        push(0, tile + 32'(512 * l), px * bb, 32'(((yb + l) * w + xb) * bb));
                    idx++;
                end
            end
        end
    endtask

    // monitor: backpressure, table responses, request checking
    always @(negedge clk) begin
        bit r;
        int k;
        cyc++;
        if (cyc > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rsp_valid) rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = ent(pend_idx);
            end
        end
        if (want_done) begin
            want_done = 0;
            chk(done == 1'b1, "R10 done one cycle after last accept", longint'(done), 1);
        end
        if (done) done_cnt++;
        r = (($urandom % 4) != 0) && rst_n;
        req_ready = r;
        if (req_valid && r) begin
            k = got - got0;
            if (k >= e_n) begin
                chk(0, "R6 request beyond end of frame", longint'(req_addr), 0);
            end else begin
                checks++;
                if (req_table !== e_tbl[k] || req_addr !== e_addr[k] ||
                    int'(req_len) != e_len[k] || req_dst !== e_dst[k]) begin
                    errors++;
                    $display("FAIL R3/R4/R8/R9 req %0d actual=%0b/%h/%0d/%h expected=%0b/%h/%0d/%h",
                             k, req_table, req_addr, req_len, req_dst,
                             e_tbl[k], e_addr[k], e_len[k], e_dst[k]);
                end
                if (e_tbl[k]) begin
                    pend = 1 + int'($urandom % 3);
                    pend_idx = int'((e_addr[k] - e_base) >> 1);
                end
            end
            got++;
            if (got - got0 == e_n) want_done = 1;
        end
    end

    task automatic run(input bit lin, input logic [1:0] dep, input int w, input int h,
                       input logic [31:0] braw, input bit perturb, input string tag);
        int d0;
        bit fin;
        build(lin, dep, w, h, braw);
        @(negedge clk);
        got0 = got;
        d0 = done_cnt;
        cfg_linear = lin; cfg_depth = dep;
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_table_base = braw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (e_n == 0) begin
            chk(done == 1'b1 && !req_valid, {tag, " R2 empty frame done"}, longint'(done), 1);
        end else begin
            chk(busy == 1'b1, {tag, " R10 busy after start"}, longint'(busy), 1);
        end
        fin = 0;
        for (int i = 0; i < 40000 && !fin; i++) begin
            if (perturb && i == 20) begin              // R11
                cfg_linear = ~lin; cfg_depth = dep + 2'd1;
                cfg_width = DIM_W'(w / 2 + 1); cfg_height = DIM_W'(h + 7);
                cfg_table_base = braw ^ 32'h0100_0000;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done_cnt > d0 && !busy) fin = 1;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(fin, {tag, " R10 frame finished"}, longint'(fin), 1);
        chk(got - got0 == e_n, {tag, " R6 request count"}, longint'(got - got0), longint'(e_n));
        chk(done_cnt - d0 == 1, {tag, " R10 single done"}, longint'(done_cnt - d0), 1);
        chk(!busy && !req_valid, {tag, " R11 idle after frame"}, longint'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req_valid, "R1 reset idle", longint'({busy, done, req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !req_valid, "R1 idle after reset", longint'({busy, done, req_valid}), 0);

        run(0, 2'd0, 640, 480, 32'h0000_01FF, 0, "zero base R2");
        run(1, 2'd0, 0, 480, 32'h0200_0000, 0, "zero width R2");
        run(0, 2'd0, 1100, 300, 32'h0123_4A00, 0, "tiled8 clip R7");
        run(0, 2'd1, 512, 256, 32'h0040_0000, 0, "tiled16 exact R5");
        run(0, 2'd3, 300, 130, 32'h7000_0200, 0, "tiled32 code3 R5");
        run(0, 2'd2, 130, 1, 32'h0000_0400, 0, "tiled32 one line R7");
        run(1, 2'd0, 640, 480, 32'h0100_0000, 0, "linear8 R9");
        run(1, 2'd2, 128, 32, 32'h0300_0000, 0, "linear32 one chunk R9");
        run(0, 2'd0, 700, 200, 32'h0500_0000, 1, "perturb R11");
        run(1, 2'd1, 320, 240, 32'h0600_0000, 1, "perturb linear R11");

        for (int f = 0; f < 6; f++) begin
            run(1'($urandom % 2), 2'($urandom % 4), 1 + int'($urandom % 1200),
                1 + int'($urandom % 300), $urandom | 32'h0000_0200, 0, "random R4 R8 R9");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule